// File: doc/BRIEF.md
# Track Jump Kick-Brake Controller

This block moves an optical pickup's tracking actuator across a chosen number of tracks when a host asks for it. A start strobe captures a target track count, from 1 to 100, and a direction. The controller then opens the tracking loop and drives the actuator. It counts single-cycle track-crossing pulses that come from zero crossings of the tracking error. When the count is reached, it applies a timed brake and closes the loop again. It then holds a raised servo gain for a prescaled window of about 50 ms, so that the loop locks onto the new track reliably.

Short jumps (1 to 4 tracks) accelerate for the first half of the crossings and decelerate with reversed drive for the rest. Longer jumps (5 to 100 tracks) run a speed loop. Each crossing ends one measured interval. The drive level is lowered when the crossings arrive too fast and raised when they arrive too slowly, and it never exceeds a programmable maximum. Kick amplitude, drive ceiling, target interval and brake length are live register inputs.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and nothing applies back-pressure. The host must hold the register inputs steady while a jump runs.

Top module: `trk_jump_ctrl`

## Requirements
- R1: Out of reset and while idle, `drv_mode` is 0 (equaliser pass-through), `servo_closed` is 1, and `gain_up`, `done` and `drv_level` are 0.
- R2: A start with an effective target T of 1 to 4 enters the kick phase. In this phase `drv_mode`=1, `drv_dir` equals the captured direction, `servo_closed`=0, and `drv_level`=min(`kick_amp`, `max_drive`). The phase lasts until (T+1)/2 crossings have been counted, rounded down.
- R3: For a short jump with T≥2, the remaining crossings up to T are driven with `drv_mode`=1, the same level and `drv_dir` inverted.
- R4: A start with T of 5 to 100 enters the speed phase with `drv_mode`=1 and `drv_dir` equal to the captured direction. The level starts at min(`kick_amp`, `max_drive`). At each crossing, the number of cycles since the previous crossing (or since the start) is compared with `tgt_ivl`. If it is shorter, the level drops by STEP with a floor of 0. If it is longer, the level rises by STEP, capped at `max_drive`. If it is equal, the level holds.
- R5: The cycle after the T-th crossing, the brake phase begins. It lasts `brake_len` cycles, with 0 treated as 1. During it `drv_mode`=2, `drv_dir` is the inverse of the captured direction, `drv_level`=0 and `servo_closed`=0.
- R6: After the brake, `drv_mode`=0, `servo_closed`=1 and `gain_up`=1 for exactly PRESC×GAIN_TICKS cycles.
- R7: `done` is high for exactly one cycle, the cycle after the gain window ends, and the block is then idle.
- R8: A start strobe during a jump is ignored: the target and direction of the running jump are unchanged.
- R9: A start with a target of 0 pulses `done` in the next cycle and produces no drive, no open loop and no gain-up.
- R10: Crossing pulses during the brake or gain phase have no effect on their durations.
- R11: Target values above 100 are treated as 100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Jump request strobe, taken only while idle |
| jump_dir | input | 1 | Jump direction, captured at start |
| jump_tracks | input | 7 | Target track count, captured at start |
| xing | input | 1 | One-cycle track-crossing pulse |
| kick_amp | input | 8 | Kick drive amplitude |
| max_drive | input | 8 | Drive level ceiling |
| tgt_ivl | input | 12 | Target crossing interval in cycles |
| brake_len | input | 10 | Brake duration in cycles |
| drv_mode | output | 2 | 0 pass-through, 1 kick, 2 brake |
| drv_dir | output | 1 | Drive direction |
| drv_level | output | 8 | Drive amplitude |
| servo_closed | output | 1 | Tracking loop closed select |
| gain_up | output | 1 | Raised servo gain select |
| done | output | 1 | Jump completion pulse |

## Verification
The hardest state to reach is the speed loop at its limits. Reaching it needs long runs of crossings whose spacing sits on both sides of the target interval, so that the level is pushed down to zero and up against a lowered ceiling. The stimulus draws many long jumps with random gaps and random targets, and adds directed jumps with fixed fast or slow spacing. A start strobe inside a running short jump is placed by the bench at a chosen crossing, and crossing noise is injected during brake and gain phases.

// File: rtl/trk_jump_pkg.sv
package trk_jump_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_KICK  = 3'd1,
    ST_DECEL = 3'd2,
    ST_SPEED = 3'd3,
    ST_BRAKE = 3'd4,
    ST_GAIN  = 3'd5
  } jump_state_e;

  typedef enum logic [1:0] {
    DRV_PASS  = 2'd0,
    DRV_KICK  = 2'd1,
    DRV_BRAKE = 2'd2
  } drv_mode_e;
endpackage

// File: rtl/jt_xing_count.sv
module jt_xing_count #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             xing,
  input  logic [CNT_W-1:0] tgt,
  output logic             at_half,
  output logic             at_all
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;
  logic [CNT_W:0]   half_w;
  logic [CNT_W-1:0] half;

  assign cnt_nx  = cnt_q + 1'b1;
  assign half_w  = ({1'b0, tgt} + 1'b1) >> 1;
  assign half    = half_w[CNT_W-1:0];
  assign at_half = cnt_en && xing && (cnt_nx == half);
  assign at_all  = cnt_en && xing && (cnt_nx == tgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (cnt_en && xing)   cnt_q <= cnt_nx;
  end

  // R2 / R3: the count never reaches the target while counting is enabled
  a_r2_count_below_target: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |-> (cnt_q < tgt));
endmodule

// File: rtl/jt_win_timer.sv
module jt_win_timer #(
  parameter int DIV   = 1,
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [LIM_W-1:0] limit,
  output logic             last
);
  localparam int PRE_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [LIM_W-1:0] tcnt_q;
  logic [LIM_W-1:0] lim_eff;
  logic             tick;

  assign lim_eff = (limit == '0) ? LIM_W'(1) : limit;

  generate
    if (DIV > 1) begin : g_pre
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         pre_q <= '0;
        else if (!run)                      pre_q <= '0;
        else if (pre_q == PRE_W'(DIV - 1))  pre_q <= '0;
        else                                pre_q <= pre_q + 1'b1;
      end
      assign tick = run && (pre_q == PRE_W'(DIV - 1));
    end else begin : g_nopre
      assign tick = run;
    end
  endgenerate

  assign last = tick && (tcnt_q == lim_eff - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tcnt_q <= '0;
    else if (!run)   tcnt_q <= '0;
    else if (last)   tcnt_q <= '0;
    else if (tick)   tcnt_q <= tcnt_q + 1'b1;
  end

  // R5 / R6: the window counter stays inside the programmed length
  a_r5_window_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (tcnt_q < lim_eff));
endmodule

// File: rtl/jt_speed_reg.sv
module jt_speed_reg #(
  parameter int AMP_W = 8,
  parameter int IVL_W = 12,
  parameter int STEP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AMP_W-1:0] load_val,
  input  logic             active,
  input  logic             xing,
  input  logic [IVL_W-1:0] tgt_ivl,
  input  logic [AMP_W-1:0] max_drive,
  output logic [AMP_W-1:0] level
);
  localparam logic [AMP_W-1:0] STEP_V = AMP_W'(STEP);

  logic [IVL_W-1:0] ivl_q;
  logic [AMP_W-1:0] level_q;
  logic [AMP_W:0]   sum_w;
  logic [AMP_W-1:0] up_val;
  logic [AMP_W-1:0] dn_val;

  assign sum_w  = {1'b0, level_q} + {1'b0, STEP_V};
  assign up_val = (sum_w > {1'b0, max_drive}) ? max_drive : sum_w[AMP_W-1:0];
  assign dn_val = (level_q > STEP_V) ? (level_q - STEP_V) : '0;
  assign level  = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ivl_q <= '0;
    else if (load)                ivl_q <= '0;
    else if (active) begin
      if (xing)                   ivl_q <= '0;
      else if (ivl_q != '1)       ivl_q <= ivl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   level_q <= '0;
    else if (load)                level_q <= load_val;
    else if (active && xing) begin
      if (ivl_q < tgt_ivl)        level_q <= dn_val;
      else if (ivl_q > tgt_ivl)   level_q <= up_val;
    end
  end

  // R4: a slow crossing never lifts the level above the ceiling
  a_r4_level_capped: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xing && !load && (ivl_q > tgt_ivl)) |=> (level_q <= $past(max_drive)));
  // R4: a fast crossing never raises the level
  a_r4_fast_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (active && xing && !load && (ivl_q < tgt_ivl)) |=> (level_q <= $past(level_q)));
  // R4: level only moves at a crossing or a load
  a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(active && xing)) |=> $stable(level_q));
endmodule

// File: rtl/trk_jump_ctrl.sv
module trk_jump_ctrl
  import trk_jump_pkg::*;
#(
  parameter int MAX_TRACKS = 100,
  parameter int SHORT_MAX  = 4,
  parameter int AMP_W      = 8,
  parameter int IVL_W      = 12,
  parameter int BRK_W      = 10,
  parameter int STEP       = 4,
  parameter int PRESC      = 10000,
  parameter int GAIN_TICKS = 1000
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic                               jump_dir,
  input  logic [$clog2(MAX_TRACKS+1)-1:0]    jump_tracks,
  input  logic                               xing,
  input  logic [AMP_W-1:0]                   kick_amp,
  input  logic [AMP_W-1:0]                   max_drive,
  input  logic [IVL_W-1:0]                   tgt_ivl,
  input  logic [BRK_W-1:0]                   brake_len,
  output logic [1:0]                         drv_mode,
  output logic                               drv_dir,
  output logic [AMP_W-1:0]                   drv_level,
  output logic                               servo_closed,
  output logic                               gain_up,
  output logic                               done
);
  localparam int CNT_W = $clog2(MAX_TRACKS + 1);
  localparam int GT_W  = $clog2(GAIN_TICKS + 1);
  localparam logic [CNT_W-1:0] MAX_V   = CNT_W'(MAX_TRACKS);
  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_MAX);

  jump_state_e      state_q;
  logic [CNT_W-1:0] tgt_q;
  logic             dir_q;
  logic             done_q;
  logic [CNT_W-1:0] tgt_eff;
  logic             accept;
  logic             at_half;
  logic             at_all;
  logic             cnt_en;
  logic             brk_last;
  logic             win_last;
  logic [AMP_W-1:0] level;
  logic [AMP_W-1:0] load_val;

  assign tgt_eff  = (jump_tracks > MAX_V) ? MAX_V : jump_tracks;
  assign accept   = (state_q == ST_IDLE) && start;
  assign cnt_en   = (state_q == ST_KICK) || (state_q == ST_DECEL) || (state_q == ST_SPEED);
  assign load_val = (kick_amp > max_drive) ? max_drive : kick_amp;

  jt_xing_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (accept),
    .cnt_en  (cnt_en),
    .xing    (xing),
    .tgt     (tgt_q),
    .at_half (at_half),
    .at_all  (at_all)
  );

  jt_speed_reg #(.AMP_W(AMP_W), .IVL_W(IVL_W), .STEP(STEP)) u_speed (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_val  (load_val),
    .active    (state_q == ST_SPEED),
    .xing      (xing),
    .tgt_ivl   (tgt_ivl),
    .max_drive (max_drive),
    .level     (level)
  );

  jt_win_timer #(.DIV(1), .LIM_W(BRK_W)) u_brake (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_BRAKE),
    .limit (brake_len),
    .last  (brk_last)
  );

  jt_win_timer #(.DIV(PRESC), .LIM_W(GT_W)) u_gain (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state_q == ST_GAIN),
    .limit (GT_W'(GAIN_TICKS)),
    .last  (win_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          if (tgt_eff == '0) begin
            done_q <= 1'b1;
          end else begin
            tgt_q   <= tgt_eff;
            dir_q   <= jump_dir;
            state_q <= (tgt_eff <= SHORT_V) ? ST_KICK : ST_SPEED;
          end
        end
        ST_KICK: begin
          if (at_all)       state_q <= ST_BRAKE;
          else if (at_half) state_q <= ST_DECEL;
        end
        ST_DECEL: if (at_all) state_q <= ST_BRAKE;
        ST_SPEED: if (at_all) state_q <= ST_BRAKE;
        ST_BRAKE: if (brk_last) state_q <= ST_GAIN;
        ST_GAIN: if (win_last) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    drv_mode     = DRV_PASS;
    drv_dir      = 1'b0;
    drv_level    = '0;
    servo_closed = 1'b1;
    gain_up      = 1'b0;
    unique case (state_q)
      ST_KICK, ST_SPEED: begin
        drv_mode = DRV_KICK; drv_dir = dir_q; drv_level = level; servo_closed = 1'b0;
      end
      ST_DECEL: begin
        drv_mode = DRV_KICK; drv_dir = ~dir_q; drv_level = level; servo_closed = 1'b0;
      end
      ST_BRAKE: begin
        drv_mode = DRV_BRAKE; drv_dir = ~dir_q; servo_closed = 1'b0;
      end
      ST_GAIN: gain_up = 1'b1;
      default: ;
    endcase
  end

  assign done = done_q;

  // R8: captured target and direction hold for the whole jump
  a_r8_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q != ST_IDLE) && ($past(state_q) != ST_IDLE)) |-> ($stable(tgt_q) && $stable(dir_q)));
  // R7: a completion pulse only follows the gain window or a zero target
  a_r7_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (($past(state_q) == ST_GAIN) || ($past(start) && ($past(state_q) == ST_IDLE))));
  // R6: the gain window is entered only from the brake phase
  a_r6_gain_after_brake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gain_up) |-> ($past(state_q) == ST_BRAKE));
  // R5: the brake phase is entered only after the final crossing
  a_r5_brake_after_count: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_BRAKE) && ($past(state_q) != ST_BRAKE)) |-> $past(at_all));
  // R1: idle keeps the loop closed with no gain-up
  a_r1_idle_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (servo_closed && !gain_up));
endmodule

// File: tb/tb_trk_jump_ctrl.sv
module tb_trk_jump_ctrl;
  localparam int PRESC = 4;
  localparam int GT    = 5;
  localparam int STEP  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       jump_dir = 1'b0;
  logic [6:0] jump_tracks = '0;
  logic       xing = 1'b0;
  logic [7:0] kick_amp = 8'd60;
  logic [7:0] max_drive = 8'd200;
  logic [11:0] tgt_ivl = 12'd10;
  logic [9:0] brake_len = 10'd6;
  logic [1:0] drv_mode;
  logic       drv_dir;
  logic [7:0] drv_level;
  logic       servo_closed;
  logic       gain_up;
  logic       done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  trk_jump_ctrl #(.PRESC(PRESC), .GAIN_TICKS(GT), .STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .jump_dir(jump_dir),
    .jump_tracks(jump_tracks), .xing(xing), .kick_amp(kick_amp),
    .max_drive(max_drive), .tgt_ivl(tgt_ivl), .brake_len(brake_len),
    .drv_mode(drv_mode), .drv_dir(drv_dir), .drv_level(drv_level),
    .servo_closed(servo_closed), .gain_up(gain_up), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {drv_mode, drv_dir, servo_closed, gain_up, done} + (int'(drv_level) << 8);
  endfunction

  function automatic int pack_exp(int mode, int dir, int lvl, int closed, int gu, int dn);
    return (mode << 4) + (dir << 3) + (closed << 2) + (gu << 1) + dn + (lvl << 8);
  endfunction

  function automatic int next_level(int lvl, int meas, int tivl, int maxd);
    if (meas < tivl) return (lvl > STEP) ? lvl - STEP : 0;
    if (meas > tivl) return (lvl + STEP > maxd) ? maxd : lvl + STEP;
    return lvl;
  endfunction

  task automatic expect_state(input string req, input int e);
    chk(outs() == e, req, outs(), e);
  endtask

  // gaps[i] = idle cycles before crossing i; mid_at >= 0 injects a start strobe
  task automatic run_jump(input int tgt, input bit d, input int gmin, input int gmax,
                          input bit noise, input int mid_at);
    int eff, half, lvl, beff;
    eff  = (tgt > 100) ? 100 : tgt;
    half = (eff + 1) / 2;
    lvl  = (int'(kick_amp) > int'(max_drive)) ? int'(max_drive) : int'(kick_amp);
    beff = (brake_len == 0) ? 1 : int'(brake_len);
    jump_tracks = 7'(tgt); jump_dir = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (eff == 0) begin
      expect_state("R9 zero target done", pack_exp(0, 0, 0, 1, 0, 1));
      @(negedge clk);
      expect_state("R9 zero target idle", pack_exp(0, 0, 0, 1, 0, 0));
      return;
    end
    for (int i = 1; i <= eff; i++) begin
      int g, e;
      bit rev;
      g = gmin + int'($urandom_range(gmax - gmin));
      rev = (eff <= 4) && (i > half);
      e = pack_exp(1, rev ? int'(!d) : int'(d), lvl, 0, 0, 0);
      xing = 1'b0;
      for (int k = 0; k < g; k++) begin
        if (eff <= 4) expect_state(rev ? "R3 decel phase" : "R2 kick phase", e);
        else          expect_state("R4 speed phase", e);
        if (i == mid_at && k == 0) begin
          start = 1'b1; jump_tracks = 7'd90; jump_dir = !d;
        end
        @(negedge clk);
        start = 1'b0;
      end
      if (eff > 4) expect_state("R4 speed level", e);
      xing = 1'b1;
      @(negedge clk);
      if (eff > 4) lvl = next_level(lvl, g, int'(tgt_ivl), int'(max_drive));
    end
    xing = 1'b0;
    for (int k = 0; k < beff; k++) begin
      expect_state(noise ? "R10 brake under noise" : "R5 brake phase", pack_exp(2, int'(!d), 0, 0, 0, 0));
      if (noise) xing = 1'($urandom_range(1));
      @(negedge clk);
    end
    for (int k = 0; k < PRESC * GT; k++) begin
      expect_state(noise ? "R10 gain under noise" : "R6 gain window", pack_exp(0, 0, 0, 1, 1, 0));
      if (noise) xing = 1'($urandom_range(1));
      @(negedge clk);
    end
    xing = 1'b0;
    expect_state("R7 done pulse", pack_exp(0, 0, 0, 1, 0, 1));
    @(negedge clk);
    expect_state("R7 done one cycle", pack_exp(0, 0, 0, 1, 0, 0));
  endtask

  initial begin
    repeat (1000000 / 5) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    expect_state("R1 reset state", pack_exp(0, 0, 0, 1, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    xing = 1'b1; @(negedge clk); xing = 1'b0;
    expect_state("R1 idle ignores crossing", pack_exp(0, 0, 0, 1, 0, 0));

    // directed short jumps
    kick_amp = 8'd90; max_drive = 8'd70; brake_len = 10'd3;
    run_jump(1, 1'b0, 1, 4, 1'b0, -1);
    run_jump(2, 1'b1, 0, 3, 1'b0, -1);
    run_jump(3, 1'b0, 2, 5, 1'b0, -1);
    run_jump(4, 1'b1, 1, 6, 1'b0, 2);      // R8 start during jump
    run_jump(0, 1'b1, 1, 1, 1'b0, -1);     // R9
    brake_len = 10'd0;
    run_jump(4, 1'b0, 1, 2, 1'b1, 3);      // R5 zero brake length, R10 noise

    // long jumps: too fast drives level to zero, too slow hits the ceiling
    kick_amp = 8'd20; max_drive = 8'd100; tgt_ivl = 12'd15; brake_len = 10'd5;
    run_jump(12, 1'b0, 2, 4, 1'b0, -1);
    run_jump(40, 1'b1, 25, 30, 1'b0, -1);
    max_drive = 8'd30;
    run_jump(9, 1'b0, 15, 15, 1'b1, -1);
    run_jump(5, 1'b1, 14, 16, 1'b0, -1);
    run_jump(127, 1'b0, 0, 3, 1'b0, -1);   // R11 clamp to 100

    // constrained random
    for (int n = 0; n < 30; n++) begin
      kick_amp  = 8'($urandom_range(255));
      max_drive = 8'($urandom_range(255));
      tgt_ivl   = 12'($urandom_range(30, 2));
      brake_len = 10'($urandom_range(12));
      run_jump(int'($urandom_range(110)), 1'($urandom_range(1)), 0, 30,
               1'($urandom_range(1)), -1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule